// File: doc/BRIEF.md
# Dual Timer Register Front End

This block is the bus-facing half of a two-channel down-counting timer. It sits on a 32-bit APB port, decodes a 4 KB register window and turns each access into per-channel write strobes and read selections. The counters are not part of the block. They take the strobes and the shared write data, and they present their load, count and control words, their raw interrupt flag and their interrupt-enable bit for readback.

Each channel has a 32-byte slice of the window. The upper part of the window holds two integration-test registers and a fixed identification block. One integration register selects test mode. In test mode the second register drives the channel interrupt outputs directly, so interrupt wiring can be checked without running a counter. A combined interrupt output is the OR of the channel outputs. Every access completes with no wait states and no error response.

Top module: `dual_timer_apb_front`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0.
- R2: A write access phase (`psel`, `penable` and `pwrite` all 1) asserts one strobe for that cycle only. An aligned write to channel n at n×0x20 + 0x00 asserts `ch_load_we[n]`, + 0x08 asserts `ch_ctrl_we[n]` and + 0x18 asserts `ch_bgload_we[n]`. `ch_wdata` carries `pwdata`.
- R3: A write of any value to channel n at n×0x20 + 0x0C asserts `ch_intclr[n]`, which tells the channel to clear its raw interrupt flag.
- R4: Channel reads return the following. Offset 0x00 and offset 0x18 both return the channel's load word. Offset 0x04 returns its count word. Offset 0x08 returns its control word, zero-extended. Offset 0x10 returns the raw flag in bit 0. Offset 0x14 returns raw AND enable in bit 0. All other bits read 0.
- R5: The test-mode register at 0xF00 holds bit 0 only and reads it back with all upper bits 0. The forced-output register at 0xF04 takes bits [NUM_CH-1:0] and always reads as 0.
- R6: When test mode is 0, `irq_ch[n]` = raw[n] AND enable[n]. When it is 1, `irq_ch[n]` = forced-output bit n. A register write changes the outputs from the cycle after the access.
- R7: `irq_any` is the OR of all bits of `irq_ch`.
- R8: The twelve words at 0xFD0, 0xFD4, …, 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Unmapped offsets read 0. Writes to unmapped offsets, to the count word (0x04), to the two status words (0x10, 0x14) or to the ID block raise no strobe and change no register.
- R10: Reset (synchronous, active high) clears both integration registers, so the normal interrupt path is selected.
- R11: No strobe is raised in the setup phase (`penable` 0) or in a read access.
- R12: An offset with `paddr[1:0]` not 0 is treated as unmapped: it reads 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | APB byte offset within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (combinational) |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ch_wdata | output | 32 | Write data to the channels |
| ch_load_we | output | NUM_CH | Load-and-restart write strobe, per channel |
| ch_ctrl_we | output | NUM_CH | Control write strobe, per channel |
| ch_bgload_we | output | NUM_CH | Background-load write strobe, per channel |
| ch_intclr | output | NUM_CH | Interrupt-clear strobe, per channel |
| ch_load_rd | input | NUM_CH*32 | Load word of each channel |
| ch_value_rd | input | NUM_CH*32 | Current count of each channel |
| ch_ctrl_rd | input | NUM_CH*CTRL_W | Control word of each channel |
| ch_raw_irq | input | NUM_CH | Raw interrupt flag of each channel |
| ch_irq_en | input | NUM_CH | Interrupt enable of each channel |
| irq_ch | output | NUM_CH | Per-channel interrupt outputs |
| irq_any | output | 1 | OR of the channel interrupts |

## Verification
The bench targets the edges of the address decode. It uses the gap at +0x1C, channel slices past the last channel, the hole just below the ID block and misaligned offsets. A decoder that is loose on any of these would return channel data or fire a strobe where 0 and silence are required. It reads both load aliases and the write-only forced-output register; a mux that drops the alias or exposes the register would give the wrong word. It switches test mode on and off while raw flags and enables vary at random. This exposes a mux that picks the wrong source, forgets the enable mask, or lets a setup-phase or read cycle load the integration registers.

// File: rtl/dtf_pkg.sv
package dtf_pkg;

    localparam int PADDR_W = 12;
    localparam int WORD_W  = 32;

    localparam logic [9:0] ITCTL_WORD = 10'h3C0;
    localparam logic [9:0] ITOUT_WORD = 10'h3C1;

    typedef enum logic [2:0] {
        CR_LOAD   = 3'd0,
        CR_VALUE  = 3'd1,
        CR_CTRL   = 3'd2,
        CR_INTCLR = 3'd3,
        CR_RAW    = 3'd4,
        CR_MASKED = 3'd5,
        CR_BGLOAD = 3'd6,
        CR_RSVD   = 3'd7
    } chreg_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CHAN,
        RG_ITCTL,
        RG_ITOUT,
        RG_ID
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [6:0]  chan;
        chreg_e      creg;
        logic [3:0]  id_idx;
    } dec_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h23;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h1B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/dtf_decode.sv
module dtf_decode
    import dtf_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [PADDR_W-1:0] paddr,
    output dec_t               dec
);
    logic aligned;
    assign aligned = (paddr[1:0] == 2'b00);

    always_comb begin
        dec.region = RG_NONE;
        dec.chan   = paddr[11:5];
        dec.creg   = chreg_e'(paddr[4:2]);
        dec.id_idx = {paddr[5:4] - 2'd1, paddr[3:2]};
        if (aligned) begin
            if (paddr[11:2] == ITCTL_WORD)
                dec.region = RG_ITCTL;
            else if (paddr[11:2] == ITOUT_WORD)
                dec.region = RG_ITOUT;
            else if (paddr[11:6] == 6'h3F && paddr[5:4] != 2'b00)
                dec.region = RG_ID;
            else if (int'(paddr[11:5]) < NUM_CH && paddr[4:2] != 3'd7)
                dec.region = RG_CHAN;
        end
    end
endmodule

// File: rtl/dtf_irq.sv
module dtf_irq #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_out,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] raw,
    input  logic [NUM_CH-1:0] en,
    output logic              it_mode,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);
    logic [NUM_CH-1:0] it_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            it_mode <= 1'b0;
            it_bits <= '0;
        end else begin
            if (wr_ctl) it_mode <= wbits[0];
            if (wr_out) it_bits <= wbits;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            irq_ch[i] = it_mode ? it_bits[i] : (raw[i] & en[i]);
    end

    assign irq_any = |irq_ch;

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!it_mode && it_bits == '0));

    p_forced_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (it_mode && $past(wr_out) && !$past(rst)) |-> (irq_ch == $past(wbits)));

    p_any_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_any) |-> (irq_ch != '0));
endmodule

// File: rtl/dtf_rdmux.sv
module dtf_rdmux
    import dtf_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CTRL_W = 8
) (
    input  dec_t                     dec,
    input  logic                     it_mode,
    input  logic [NUM_CH*WORD_W-1:0] ch_load_rd,
    input  logic [NUM_CH*WORD_W-1:0] ch_value_rd,
    input  logic [NUM_CH*CTRL_W-1:0] ch_ctrl_rd,
    input  logic [NUM_CH-1:0]        ch_raw_irq,
    input  logic [NUM_CH-1:0]        ch_irq_en,
    output logic [WORD_W-1:0]        rdata
);
    logic [WORD_W-1:0] sel_load, sel_value;
    logic [CTRL_W-1:0] sel_ctrl;
    logic              sel_raw, sel_en;

    always_comb begin
        sel_load  = '0;
        sel_value = '0;
        sel_ctrl  = '0;
        sel_raw   = 1'b0;
        sel_en    = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.chan == 7'(i)) begin
                sel_load  = ch_load_rd[i*WORD_W +: WORD_W];
                sel_value = ch_value_rd[i*WORD_W +: WORD_W];
                sel_ctrl  = ch_ctrl_rd[i*CTRL_W +: CTRL_W];
                sel_raw   = ch_raw_irq[i];
                sel_en    = ch_irq_en[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.region)
            RG_CHAN: begin
                case (dec.creg)
                    CR_LOAD, CR_BGLOAD: rdata = sel_load;
                    CR_VALUE:           rdata = sel_value;
                    CR_CTRL:            rdata = WORD_W'(sel_ctrl);
                    CR_RAW:             rdata = WORD_W'(sel_raw);
                    CR_MASKED:          rdata = WORD_W'(sel_raw & sel_en);
                    default:            rdata = '0;
                endcase
            end
            RG_ITCTL: rdata = WORD_W'(it_mode);
            RG_ID:    rdata = WORD_W'(id_byte(dec.id_idx));
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_timer_apb_front.sv
module dual_timer_apb_front
    import dtf_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CTRL_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [PADDR_W-1:0]       paddr,
    input  logic [WORD_W-1:0]        pwdata,
    output logic [WORD_W-1:0]        prdata,
    output logic                     pready,
    output logic                     pslverr,
    output logic [WORD_W-1:0]        ch_wdata,
    output logic [NUM_CH-1:0]        ch_load_we,
    output logic [NUM_CH-1:0]        ch_ctrl_we,
    output logic [NUM_CH-1:0]        ch_bgload_we,
    output logic [NUM_CH-1:0]        ch_intclr,
    input  logic [NUM_CH*WORD_W-1:0] ch_load_rd,
    input  logic [NUM_CH*WORD_W-1:0] ch_value_rd,
    input  logic [NUM_CH*CTRL_W-1:0] ch_ctrl_rd,
    input  logic [NUM_CH-1:0]        ch_raw_irq,
    input  logic [NUM_CH-1:0]        ch_irq_en,
    output logic [NUM_CH-1:0]        irq_ch,
    output logic                     irq_any
);
    dec_t dec;
    logic wr_acc;
    logic it_mode;

    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
    assign ch_wdata = pwdata;
    assign wr_acc   = psel & penable & pwrite;

    dtf_decode #(.NUM_CH(NUM_CH)) u_decode (
        .paddr (paddr),
        .dec   (dec)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_strobe
        logic hit;
        assign hit             = wr_acc && dec.region == RG_CHAN && dec.chan == 7'(n);
        assign ch_load_we[n]   = hit && dec.creg == CR_LOAD;
        assign ch_ctrl_we[n]   = hit && dec.creg == CR_CTRL;
        assign ch_bgload_we[n] = hit && dec.creg == CR_BGLOAD;
        assign ch_intclr[n]    = hit && dec.creg == CR_INTCLR;
    end

    dtf_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_acc && dec.region == RG_ITCTL),
        .wr_out  (wr_acc && dec.region == RG_ITOUT),
        .wbits   (pwdata[NUM_CH-1:0]),
        .raw     (ch_raw_irq),
        .en      (ch_irq_en),
        .it_mode (it_mode),
        .irq_ch  (irq_ch),
        .irq_any (irq_any)
    );

    dtf_rdmux #(.NUM_CH(NUM_CH), .CTRL_W(CTRL_W)) u_rdmux (
        .dec         (dec),
        .it_mode     (it_mode),
        .ch_load_rd  (ch_load_rd),
        .ch_value_rd (ch_value_rd),
        .ch_ctrl_rd  (ch_ctrl_rd),
        .ch_raw_irq  (ch_raw_irq),
        .ch_irq_en   (ch_irq_en),
        .rdata       (prdata)
    );

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({ch_load_we, ch_ctrl_we, ch_bgload_we, ch_intclr}) <= 1);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable && pwrite) |->
        ({ch_load_we, ch_ctrl_we, ch_bgload_we, ch_intclr} == '0));

    p_misaligned_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (paddr[1:0] != 2'b00) |->
        ({ch_load_we, ch_ctrl_we, ch_bgload_we, ch_intclr} == '0 && prdata == '0));
endmodule

// File: tb/test_dual_timer_apb_front.sv
module test_dual_timer_apb_front;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic [31:0] ch_wdata;
    logic [NCH-1:0] ch_load_we, ch_ctrl_we, ch_bgload_we, ch_intclr;
    logic [NCH*32-1:0] ch_load_rd = '0, ch_value_rd = '0;
    logic [NCH*CW-1:0] ch_ctrl_rd = '0;
    logic [NCH-1:0] ch_raw_irq = '0, ch_irq_en = '0;
    logic [NCH-1:0] irq_ch;
    logic irq_any;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit m_mode = 0;
    logic [NCH-1:0] m_bits = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_timer_apb_front #(.NUM_CH(NCH), .CTRL_W(CW)) i_dual_timer_apb_front (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .ch_wdata(ch_wdata), .ch_load_we(ch_load_we),
        .ch_ctrl_we(ch_ctrl_we), .ch_bgload_we(ch_bgload_we), .ch_intclr(ch_intclr),
        .ch_load_rd(ch_load_rd), .ch_value_rd(ch_value_rd), .ch_ctrl_rd(ch_ctrl_rd),
        .ch_raw_irq(ch_raw_irq), .ch_irq_en(ch_irq_en), .irq_ch(irq_ch), .irq_any(irq_any)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] id_ref(input int k);
        logic [7:0] tbl [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return tbl[k];
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int ch, off;
        if (a[1:0] != 0) return 0;
        if (int'(a) < NCH*32) begin
            ch = int'(a) / 32;
            off = int'(a) % 32;
            case (off)
                'h00, 'h18: return ch_load_rd[ch*32 +: 32];
                'h04: return ch_value_rd[ch*32 +: 32];
                'h08: return 32'(ch_ctrl_rd[ch*CW +: CW]);
                'h10: return 32'(ch_raw_irq[ch]);
                'h14: return 32'(ch_raw_irq[ch] & ch_irq_en[ch]);
                default: return 0;
            endcase
        end
        if (a == 12'hF00) return 32'(m_mode);
        if (a >= 12'hFD0) return 32'(id_ref((int'(a) - 'hFD0) / 4));
        return 0;
    endfunction

    // bits: [4n+0]=load [4n+1]=ctrl [4n+2]=bgload [4n+3]=intclr
    function automatic logic [4*NCH-1:0] exp_strb(input logic [11:0] a, input bit wr);
        logic [4*NCH-1:0] s = '0;
        int ch, off;
        if (!wr || a[1:0] != 0 || int'(a) >= NCH*32) return s;
        ch = int'(a) / 32;
        off = int'(a) % 32;
        case (off)
            'h00: s[4*ch+0] = 1'b1;
            'h08: s[4*ch+1] = 1'b1;
            'h18: s[4*ch+2] = 1'b1;
            'h0C: s[4*ch+3] = 1'b1;
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic [4*NCH-1:0] got_strb();
        logic [4*NCH-1:0] s;
        for (int c = 0; c < NCH; c++)
            s[4*c +: 4] = {ch_intclr[c], ch_bgload_we[c], ch_ctrl_we[c], ch_load_we[c]};
        return s;
    endfunction

    task automatic check_irq(input string tag);
        logic [NCH-1:0] e;
        e = m_mode ? m_bits : (ch_raw_irq & ch_irq_en);
        chk(irq_ch == e, {tag, " R6 irq_ch"}, 64'(irq_ch), 64'(e));
        chk(irq_any == (|e), {tag, " R7 irq_any"}, 64'(irq_any), 64'(|e));
    endtask

    task automatic apb(input logic [11:0] a, input bit wr, input logic [31:0] d);
        logic [4*NCH-1:0] es;
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        #1;
        chk(got_strb() == 0, "R11 setup phase strobe", 64'(got_strb()), 0);
        @(negedge clk);
        penable = 1;
        #1;
        es = exp_strb(a, wr);
        chk(got_strb() == es, "R2/R3/R9/R12 strobes", 64'(got_strb()), 64'(es));
        chk(pready == 1'b1 && pslverr == 1'b0, "R1 ready/err", {pready, pslverr}, 2'b10);
        if (wr) chk(ch_wdata == d, "R2 wdata", 64'(ch_wdata), 64'(d));
        else chk(prdata == exp_read(a), "R4/R5/R8/R9 read", 64'(prdata), 64'(exp_read(a)));
        @(posedge clk);
        if (wr && a == 12'hF00) m_mode = d[0];
        if (wr && a == 12'hF04) m_bits = d[NCH-1:0];
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        #1;
        check_irq("post-access");
    endtask

    function automatic logic [11:0] pick_addr();
        int r = int'($urandom_range(0, 9));
        case (r)
            0, 1, 2: return 12'($urandom_range(0, 'h3F)) & 12'hFFC;
            3: return 12'($urandom_range(0, 'h7F));
            4: return $urandom_range(0, 1) ? 12'hF00 : 12'hF04;
            5, 6: return 12'($urandom_range('hFC0, 'hFFF)) & 12'hFFC;
            7: return 12'($urandom_range('hF00, 'hF0F));
            default: return 12'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'h1DC5));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R10 reset state: normal path, test-mode register reads 0
        chk(pready == 1'b1 && pslverr == 1'b0, "R1 after reset", {pready, pslverr}, 2'b10);
        check_irq("R10 reset");
        apb(12'hF00, 0, 0);
        apb(12'hF04, 0, 0);

        // R8 ID block
        for (int k = 0; k < 12; k++) apb(12'(12'hFD0 + 4*k), 0, 0);
        apb(12'hFC0, 0, 0);
        apb(12'hFD1, 0, 0);       // R12 misaligned
        apb(12'h008 | 12'h2, 1, 32'hFF); // R12 misaligned write
        apb(12'h01C, 1, 32'h1);   // R9 gap
        apb(12'h04C, 1, 32'h1);   // R9 channel past last
        apb(12'h004, 1, 32'h5);   // R9 count word read-only
        apb(12'h030, 1, 32'h5);   // R9 status read-only
        apb(12'h02C, 1, 32'h0);   // R3 intclr with zero data

        // R6/R7 forced path
        ch_raw_irq = 2'b11; ch_irq_en = 2'b11;
        apb(12'hF04, 1, 32'h2);
        apb(12'hF00, 1, 32'hFFFF_FFFF);
        apb(12'hF00, 0, 0);       // R5 upper bits read 0
        apb(12'hF04, 0, 0);       // R5 write-only reads 0
        apb(12'hF04, 1, 32'h0);
        apb(12'hF00, 1, 32'h0);
        ch_irq_en = 2'b01;
        #1 check_irq("R6 enable mask");

        for (int it = 0; it < 600; it++) begin
            for (int c = 0; c < NCH; c++) begin
                ch_load_rd[c*32 +: 32]  = $urandom;
                ch_value_rd[c*32 +: 32] = $urandom;
                ch_ctrl_rd[c*CW +: CW]  = CW'($urandom);
            end
            ch_raw_irq = NCH'($urandom);
            ch_irq_en  = NCH'($urandom);
            apb(pick_addr(), 1'($urandom), $urandom);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule